// File: doc/BRIEF.md
# Banked Context Model Store with Set Copy

This block is the backing store behind a small cache of probability-state models used by a binary arithmetic decoder. It keeps sixteen independent banks ("sets") of models. Each set is divided into 41 lines, numbered 0 to 40. A line packs four 7-bit models into one 28-bit word. The cache moves whole lines only: a miss fills one full line, and an evicted line is written back as one full line.

Next to the line port sits a copy engine. One command names a source set and a destination set. The engine then duplicates every line of the source into the destination, one line per cycle. Decoders that run rows in parallel use this to save a model snapshot at a row boundary and to restore it at the start of the next row. While a copy runs, the line port stalls. A line read answers one cycle after it is accepted, so the request cycle plus the data cycle make a two-cycle miss service.

Top module: `cms_store`

## Requirements
- R1: During reset and in the first cycle after it, `cp_busy` and `rsp_valid` are 0 and `req_ready` is 1.
- R2: A line write stores the full 28-bit word, with model k in bits 7k+6..7k (model 0 in bits 6..0, model 3 in bits 27..21). A later read of the same set and line returns that word unchanged.
- R3: An accepted read (`req_valid`=1, `req_write`=0, `req_ready`=1 at a clock edge) raises `rsp_valid` for exactly the next cycle, with `rsp_data` holding the line. No other cycle shows `rsp_valid`=1, and writes produce no response.
- R4: A write changes only the addressed line of the addressed set. Neighbouring lines and the same line index in other sets keep their contents.
- R5: `cp_start` with source ≠ destination, sampled while idle, raises `cp_busy` from the next cycle for exactly 42 cycles (one per line plus a final write cycle). Afterwards every destination line equals the corresponding source line.
- R6: A copy leaves the source set and all uninvolved sets unchanged.
- R7: While `cp_busy` is 1, `req_ready` is 0. A request offered then is not taken: it returns no response and writes nothing.
- R8: `cp_start` sampled while `cp_busy` is 1 is ignored. The running copy keeps its length and targets, and the named sets are not modified.
- R9: A write accepted in the same cycle as a copy start takes effect before the copy. A write to a source line is carried into the destination, and a write to a destination line is overwritten by the copied data.
- R10: `cp_start` with source equal to destination finishes at once. `cp_busy` stays 0 and no line changes.
- R11: A read accepted in the same cycle as a copy start returns the line's contents from before the copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Line request present |
| req_write | input | 1 | 1 = write-back, 0 = fill read |
| req_set | input | 4 | Set selected by the request |
| req_line | input | 6 | Line index within the set (0..40) |
| req_wdata | input | 28 | Line word to write (four packed models) |
| req_ready | output | 1 | Request accepted this cycle when valid |
| rsp_valid | output | 1 | Read data strobe |
| rsp_data | output | 28 | Line word returned by a read |
| cp_start | input | 1 | Copy command strobe |
| cp_src | input | 4 | Set copied from |
| cp_dst | input | 4 | Set copied to |
| cp_busy | output | 1 | Copy in progress |

## Verification
The assertions take for granted that `req_line` and the line indices in use stay below 41. The bench keeps to this by looping only over indices 0 to 40.

The assertions also treat a request as taken only when `req_ready` is high. They do not assume the requester holds a stalled request until it is taken. The bench deliberately drops a request offered during a copy and then checks that the request had no effect.

Every line read in the bench is first written, because the store is not reset. The bench's reference copy of all 656 lines therefore never predicts an unwritten value.

// File: rtl/cms_pkg.sv
package cms_pkg;
  localparam int CMS_NUM_SETS = 16;
  localparam int CMS_LINES    = 41;
  localparam int CMS_MODELS   = 4;
  localparam int CMS_MODEL_W  = 7;

  typedef enum logic {
    RD_FROM_CACHE = 1'b0,
    RD_FROM_COPY  = 1'b1
  } cms_rd_src_e;
endpackage

// File: rtl/cms_ram.sv
module cms_ram #(
  parameter int DATA_W = 28,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cms_copy_engine.sv
module cms_copy_engine #(
  parameter int SET_W  = 4,
  parameter int LINE_W = 6,
  parameter int LINES  = 41
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SET_W-1:0]  src,
  input  logic [SET_W-1:0]  dst,
  output logic              busy,
  output logic              rd_en,
  output logic [SET_W-1:0]  rd_set,
  output logic [LINE_W-1:0] rd_line,
  output logic              wr_en,
  output logic [SET_W-1:0]  wr_set,
  output logic [LINE_W-1:0] wr_line
);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);

  logic              rd_act;
  logic              wr_pend;
  logic [LINE_W-1:0] cnt;
  logic [LINE_W-1:0] wr_line_q;
  logic [SET_W-1:0]  src_q;
  logic [SET_W-1:0]  dst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act    <= 1'b0;
      wr_pend   <= 1'b0;
      cnt       <= '0;
      wr_line_q <= '0;
      src_q     <= '0;
      dst_q     <= '0;
    end else begin
      wr_pend <= rd_act;
      if (rd_act) begin
        wr_line_q <= cnt;
        if (cnt == LAST_LINE) rd_act <= 1'b0;
        else                  cnt    <= cnt + 1'b1;
      end else if (start && !wr_pend && (src != dst)) begin
        rd_act <= 1'b1;
        cnt    <= '0;
        src_q  <= src;
        dst_q  <= dst;
      end
    end
  end

  assign busy    = rd_act | wr_pend;
  assign rd_en   = rd_act;
  assign rd_set  = src_q;
  assign rd_line = cnt;
  assign wr_en   = wr_pend;
  assign wr_set  = dst_q;
  assign wr_line = wr_line_q;
endmodule

// File: rtl/cms_req_front.sv
module cms_req_front (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_write,
  input  logic busy,
  output logic req_ready,
  output logic acc_rd,
  output logic acc_wr,
  output logic rsp_valid
);
  logic acc;

  assign req_ready = ~busy;
  assign acc       = req_valid & ~busy;
  assign acc_rd    = acc & ~req_write;
  assign acc_wr    = acc & req_write;

  always_ff @(posedge clk) begin
    if (rst) rsp_valid <= 1'b0;
    else     rsp_valid <= acc_rd;
  end
endmodule

// File: rtl/cms_store.sv
module cms_store
  import cms_pkg::*;
#(
  parameter int  NUM_SETS = CMS_NUM_SETS,
  parameter int  LINES    = CMS_LINES,
  parameter int  MODELS   = CMS_MODELS,
  parameter int  MODEL_W  = CMS_MODEL_W,
  localparam int SET_W    = $clog2(NUM_SETS),
  localparam int LINE_W   = $clog2(LINES),
  localparam int LINE_DW  = MODELS * MODEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [SET_W-1:0]   req_set,
  input  logic [LINE_W-1:0]  req_line,
  input  logic [LINE_DW-1:0] req_wdata,
  output logic               req_ready,
  output logic               rsp_valid,
  output logic [LINE_DW-1:0] rsp_data,
  input  logic               cp_start,
  input  logic [SET_W-1:0]   cp_src,
  input  logic [SET_W-1:0]   cp_dst,
  output logic               cp_busy
);
  localparam int ADDR_W = SET_W + LINE_W;

  logic              ce_rd, ce_wr;
  logic [SET_W-1:0]  ce_rd_set, ce_wr_set;
  logic [LINE_W-1:0] ce_rd_line, ce_wr_line;
  logic              fe_rd, fe_wr;

  logic               ram_we, ram_re;
  logic [ADDR_W-1:0]  ram_waddr, ram_raddr;
  logic [LINE_DW-1:0] ram_wdata, ram_rdata;
  cms_rd_src_e        rd_src;

  cms_copy_engine #(
    .SET_W (SET_W),
    .LINE_W(LINE_W),
    .LINES (LINES)
  ) u_copy (
    .clk    (clk),
    .rst    (rst),
    .start  (cp_start),
    .src    (cp_src),
    .dst    (cp_dst),
    .busy   (cp_busy),
    .rd_en  (ce_rd),
    .rd_set (ce_rd_set),
    .rd_line(ce_rd_line),
    .wr_en  (ce_wr),
    .wr_set (ce_wr_set),
    .wr_line(ce_wr_line)
  );

  cms_req_front u_front (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .busy     (cp_busy),
    .req_ready(req_ready),
    .acc_rd   (fe_rd),
    .acc_wr   (fe_wr),
    .rsp_valid(rsp_valid)
  );

  always_comb begin
    rd_src    = ce_rd ? RD_FROM_COPY : RD_FROM_CACHE;
    ram_re    = ce_rd | fe_rd;
    ram_raddr = (rd_src == RD_FROM_COPY) ? {ce_rd_set, ce_rd_line}
                                         : {req_set, req_line};
    if (ce_wr) begin
      ram_we    = 1'b1;
      ram_waddr = {ce_wr_set, ce_wr_line};
      ram_wdata = ram_rdata;
    end else begin
      ram_we    = fe_wr;
      ram_waddr = {req_set, req_line};
      ram_wdata = req_wdata;
    end
  end

  cms_ram #(
    .DATA_W(LINE_DW),
    .ADDR_W(ADDR_W)
  ) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .re   (ram_re),
    .raddr(ram_raddr),
    .rdata(ram_rdata)
  );

  assign rsp_data = ram_rdata;
endmodule

// File: rtl/cms_store_chk.sv
module cms_store_chk #(
  parameter int LINES = 41,
  parameter int SET_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_write,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             cp_start,
  input logic [SET_W-1:0] cp_src,
  input logic [SET_W-1:0] cp_dst,
  input logic             cp_busy
);
  localparam int CW = $clog2(LINES + 2) + 1;

  logic          rst_d;
  logic [CW-1:0] bcnt;

  always_ff @(posedge clk) rst_d <= rst;

  always_ff @(posedge clk) begin
    if (rst)          bcnt <= '0;
    else if (cp_busy) bcnt <= bcnt + 1'b1;
    else              bcnt <= '0;
  end

  // R1
  rst_state_chk: assert property (@(posedge clk)
    rst_d |-> (!cp_busy && !rsp_valid && req_ready));

  // R3
  rd_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  // R3
  no_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready && !req_write) |=> !rsp_valid);

  // R7
  stall_chk: assert property (@(posedge clk) disable iff (rst)
    cp_busy |-> !req_ready);

  // R5
  start_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_start && !cp_busy && (cp_src != cp_dst)) |=> cp_busy);

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    cp_busy |-> (bcnt <= CW'(LINES)));

  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cp_busy) |-> ($past(bcnt) == CW'(LINES)));

  // R8
  no_cut_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_busy && (bcnt != CW'(LINES))) |=> cp_busy);

  // R10
  same_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_start && !cp_busy && (cp_src == cp_dst)) |=> !cp_busy);
endmodule

bind cms_store cms_store_chk #(
  .LINES(LINES),
  .SET_W(SET_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .cp_start (cp_start),
  .cp_src   (cp_src),
  .cp_dst   (cp_dst),
  .cp_busy  (cp_busy)
);

// File: tb/cms_store_tb.sv
module cms_store_tb;
  localparam int NS = 16;
  localparam int NL = 41;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [3:0]  req_set = '0;
  logic [5:0]  req_line = '0;
  logic [27:0] req_wdata = '0;
  logic        req_ready;
  logic        rsp_valid;
  logic [27:0] rsp_data;
  logic        cp_start = 1'b0;
  logic [3:0]  cp_src = '0;
  logic [3:0]  cp_dst = '0;
  logic        cp_busy;

  int checks = 0;
  int fails  = 0;
  logic [27:0] ref_mem [NS][NL];

  always #10 clk = ~clk;

  cms_store u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_set(req_set), .req_line(req_line), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .cp_start(cp_start), .cp_src(cp_src), .cp_dst(cp_dst), .cp_busy(cp_busy)
  );

  function automatic logic [27:0] pat(int s, int l, int salt);
    int unsigned h;
    h = (s * 97 + l * 13 + salt * 1237 + 5) * 32'd2654435761;
    return h[31:4];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_line(int s, int l, logic [27:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_set = 4'(s); req_line = 6'(l); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check("R3 write gives no response", 32'(rsp_valid), 32'd0);
    ref_mem[s][l] = d;
  endtask

  task automatic rd_check(string req, int s, int l);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_set = 4'(s); req_line = 6'(l);
    @(negedge clk);
    req_valid = 1'b0;
    check("R3 read strobe", 32'(rsp_valid), 32'd1);
    check(req, 32'(rsp_data), 32'(ref_mem[s][l]));
  endtask

  task automatic sweep(string req);
    for (int s = 0; s < NS; s++)
      for (int l = 0; l < NL; l++)
        rd_check(req, s, l);
  endtask

  task automatic model_copy(int src, int dst);
    for (int l = 0; l < NL; l++) ref_mem[dst][l] = ref_mem[src][l];
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (cp_busy && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int n;
    logic [27:0] w;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check("R1 busy in reset", 32'(cp_busy), 32'd0);
    check("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after reset", 32'(cp_busy), 32'd0);
    check("R1 ready after reset", 32'(req_ready), 32'd1);
    check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);

    // R2: fill every line, then read all back
    for (int s = 0; s < NS; s++)
      for (int l = 0; l < NL; l++)
        wr_line(s, l, pat(s, l, 1));
    sweep("R2 full sweep readback");

    // R2: model field positions
    w = {7'h5A, 7'h33, 7'h7F, 7'h01};
    wr_line(2, 40, w);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_set = 4'd2; req_line = 6'd40;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 model0 bits 6..0", 32'(rsp_data[6:0]), 32'h01);
    check("R2 model1 bits 13..7", 32'(rsp_data[13:7]), 32'h7F);
    check("R2 model2 bits 20..14", 32'(rsp_data[20:14]), 32'h33);
    check("R2 model3 bits 27..21", 32'(rsp_data[27:21]), 32'h5A);

    // R4: write isolation
    wr_line(5, 7, 28'hABCDEF1);
    rd_check("R4 written line", 5, 7);
    rd_check("R4 line below", 5, 6);
    rd_check("R4 line above", 5, 8);
    rd_check("R4 other set low", 4, 7);
    rd_check("R4 other set high", 6, 7);

    // R5, R7, R8: copy 3 -> 9 with stall and ignored start mid-copy
    @(negedge clk);
    cp_start = 1'b1; cp_src = 4'd3; cp_dst = 4'd9;
    @(negedge clk);
    cp_start = 1'b0;
    check("R5 busy after start", 32'(cp_busy), 32'd1);
    n = 0;
    while (cp_busy && n < 200) begin
      n++;
      if (n == 3) begin
        req_valid = 1'b1; req_write = 1'b1; req_set = 4'd0; req_line = 6'd0;
        req_wdata = 28'h1234567;
        cp_start = 1'b1; cp_src = 4'd1; cp_dst = 4'd2;
        check("R7 ready low while busy", 32'(req_ready), 32'd0);
      end
      if (n == 5) begin
        req_valid = 1'b1; req_write = 1'b0; req_set = 4'd0; req_line = 6'd1;
      end
      if (n == 4 || n == 6) begin
        req_valid = 1'b0; cp_start = 1'b0;
      end
      if (n == 7) check("R7 no response while busy", 32'(rsp_valid), 32'd0);
      @(negedge clk);
    end
    req_valid = 1'b0; cp_start = 1'b0;
    check("R5 R8 busy length", 32'(n), 32'd42);
    model_copy(3, 9);
    rd_check("R7 stalled write had no effect", 0, 0);
    sweep("R5 R6 R8 after copy");

    // R9: write to source line together with copy start
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_set = 4'd4; req_line = 6'd40;
    req_wdata = 28'h0F0F0F0;
    cp_start = 1'b1; cp_src = 4'd4; cp_dst = 4'd10;
    @(negedge clk);
    req_valid = 1'b0; cp_start = 1'b0;
    ref_mem[4][40] = 28'h0F0F0F0;
    model_copy(4, 10);
    wait_idle(n);
    rd_check("R9 source write carried to destination", 10, 40);
    rd_check("R9 source write kept", 4, 40);

    // R9: write to destination line together with copy start
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_set = 4'd11; req_line = 6'd0;
    req_wdata = 28'hEEEEEEE;
    cp_start = 1'b1; cp_src = 4'd12; cp_dst = 4'd11;
    @(negedge clk);
    req_valid = 1'b0; cp_start = 1'b0;
    model_copy(12, 11);
    wait_idle(n);
    rd_check("R9 destination write overwritten", 11, 0);

    // R11: read in the start cycle returns pre-copy data
    w = ref_mem[6][3];
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_set = 4'd6; req_line = 6'd3;
    cp_start = 1'b1; cp_src = 4'd7; cp_dst = 4'd6;
    @(negedge clk);
    req_valid = 1'b0; cp_start = 1'b0;
    check("R11 read strobe at start", 32'(rsp_valid), 32'd1);
    check("R11 pre-copy data", 32'(rsp_data), 32'(w));
    model_copy(7, 6);
    wait_idle(n);

    // R10: same-set copy
    @(negedge clk);
    cp_start = 1'b1; cp_src = 4'd8; cp_dst = 4'd8;
    @(negedge clk);
    cp_start = 1'b0;
    check("R10 no busy on same set", 32'(cp_busy), 32'd0);
    @(negedge clk);
    check("R10 still idle", 32'(cp_busy), 32'd0);
    check("R10 ready kept", 32'(req_ready), 32'd1);
    sweep("R6 R10 final sweep");

    finish_run();
  end
endmodule